// File: doc/BRIEF.md
# Reset Qualifier and Power-Mode Clock Gate

This block turns a raw active-high reset pin into a clean synchronous internal reset. It also produces the clock enables that put an 8-bit controller core into its two low-power modes. The oscillator clock is halved to form the internal tick. Twelve ticks, six states of two phases each, make one machine cycle. The reset pin is looked at only once per machine cycle, at the second phase of the fifth state. It is accepted only after two back-to-back looks find it high.

Software starts the low-power modes through two control bits, one for idle and one for power-down, written with a strobe. Idle gates only the processor enable and is left on an interrupt or a reset. Power-down stops every enable and the oscillator, and only a reset ends it. The block also supplies the load values used at reset: ports, stack pointer, and the power-control register, which keeps its bit 4.

A separate power-on input `por_n` initialises the block's own flops. It is not the qualified reset.

Top module: `rst_pwr_ctl`

## Requirements
- R1: While the oscillator runs, `per_clk_en` is high on every second oscillator clock, giving the divide-by-two internal tick.
- R2: The pin is sampled on the tick that ends state 5 phase 2. This is oscillator edge 20 of each 24-edge machine cycle, counted from power-on or from the restart. `sys_rst` rises right after the second consecutive high sample.
- R3: A high level on the pin that does not cover two consecutive sample points does not assert `sys_rst`.
- R4: `sys_rst` falls after the first low sample. The machine-cycle count then restarts at state 1 phase 1, so the next sample falls 20 oscillator edges later.
- R5: A write with `pcon_idl`=1 and `pcon_pd`=0 sets `mode_idle`. In idle, `cpu_clk_en` stays low while `per_clk_en` keeps ticking.
- R6: In idle, an `irq_pend` pulse clears `mode_idle` at the next machine-cycle boundary. `cpu_clk_en` then resumes.
- R7: In power-down, `osc_run`, `per_clk_en` and `cpu_clk_en` are low, and `irq_pend` has no effect.
- R8: Only a qualified reset ends power-down. A high pin restarts the oscillator at once. Both mode bits clear one oscillator clock after `sys_rst` rises.
- R9: A write with both `pcon_idl` and `pcon_pd` set enters power-down only; `mode_idle` stays 0.
- R10: Reset load values: `port_rv`=0xFF, `sp_rv`=0x07, and `pcon_rv` equals `pcon_cur` with every bit except bit 4 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on initialisation, active low, synchronous |
| rst_pin | input | 1 | Raw reset pin, active high |
| pcon_we | input | 1 | Write strobe for the mode bits |
| pcon_idl | input | 1 | Idle request bit of the write |
| pcon_pd | input | 1 | Power-down request bit of the write |
| irq_pend | input | 1 | Interrupt pending flag |
| pcon_cur | input | 8 | Present power-control register value |
| sys_rst | output | 1 | Qualified synchronous internal reset |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral and interrupt clock enable |
| osc_run | output | 1 | Oscillator run enable |
| mode_idle | output | 1 | Idle mode bit |
| mode_pdown | output | 1 | Power-down mode bit |
| port_rv | output | 8 | Port reset value |
| sp_rv | output | 8 | Stack pointer reset value |
| pcon_rv | output | 8 | Power-control reset value |

## Verification
Two events can coincide: a restart of the machine-cycle counter and a reset sample. The restart comes from a reset release, and the sample can land at the old phase or the new one. The bench holds the pin high across a release and checks that `sys_rst` returns exactly 44 edges after the release, not 48. A second coincidence is a reset leaving power-down while the counter is frozen mid-cycle. There the sample must fall at the resumed phase, and the mode bits must clear one clock after `sys_rst` rises.

// File: rtl/rst_pwr_ctl.sv
module rst_pwr_ctl #(
  parameter int STATES    = 6,
  parameter int PHASES    = 2,
  parameter int SMP_STATE = 5,
  parameter int SMP_PHASE = 2,
  parameter int QUAL      = 2,
  parameter int W         = 8,
  parameter int KEEP_BIT  = 4,
  parameter logic [W-1:0] PORT_INIT = 8'hFF,
  parameter logic [W-1:0] SP_INIT   = 8'h07
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_pin,
  input  logic         pcon_we,
  input  logic         pcon_idl,
  input  logic         pcon_pd,
  input  logic         irq_pend,
  input  logic [W-1:0] pcon_cur,
  output logic         sys_rst,
  output logic         cpu_clk_en,
  output logic         per_clk_en,
  output logic         osc_run,
  output logic         mode_idle,
  output logic         mode_pdown,
  output logic [W-1:0] port_rv,
  output logic [W-1:0] sp_rv,
  output logic [W-1:0] pcon_rv
);
  localparam int TICKS = STATES * PHASES;
  localparam int CW    = $clog2(TICKS);
  localparam int QW    = $clog2(QUAL + 1);
  localparam logic [CW-1:0] SMP  = CW'((SMP_STATE - 1) * PHASES + SMP_PHASE - 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);
  localparam logic [QW-1:0] QMAX = QW'(QUAL);

  logic          div, wake;
  logic [CW-1:0] tick;
  logic [QW-1:0] hi;
  logic          tick_en, smp, mc_end, rel;

  assign osc_run    = ~mode_pdown | rst_pin;
  assign tick_en    = osc_run & div;
  assign smp        = tick_en && (tick == SMP);
  assign mc_end     = tick_en && (tick == LAST);
  assign rel        = smp & ~rst_pin & sys_rst;
  assign per_clk_en = tick_en & ~mode_pdown;
  assign cpu_clk_en = tick_en & ~mode_pdown & ~mode_idle;
  assign port_rv    = PORT_INIT;
  assign sp_rv      = SP_INIT;
  assign pcon_rv    = pcon_cur & (W'(1) << KEEP_BIT);

  always_ff @(posedge clk) begin
    if (!por_n || rel) begin
      div  <= 1'b0;
      tick <= '0;
    end else if (osc_run) begin
      div <= ~div;
      if (div) tick <= (tick == LAST) ? '0 : tick + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      hi      <= '0;
      sys_rst <= 1'b0;
    end else if (smp) begin
      if (rst_pin) begin
        if (hi != QMAX) hi <= hi + 1'b1;
        if (hi >= QMAX - 1'b1) sys_rst <= 1'b1;
      end else begin
        hi      <= '0;
        sys_rst <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || sys_rst) begin
      mode_idle  <= 1'b0;
      mode_pdown <= 1'b0;
      wake       <= 1'b0;
    end else if (pcon_we && pcon_pd) begin
      mode_pdown <= 1'b1;
      mode_idle  <= 1'b0;
      wake       <= 1'b0;
    end else if (pcon_we && pcon_idl) begin
      mode_idle <= 1'b1;
    end else if (mode_idle) begin
      if (mc_end && (wake || irq_pend)) begin
        mode_idle <= 1'b0;
        wake      <= 1'b0;
      end else if (irq_pend) begin
        wake <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_pwr_ctl_chk.sv
module rst_pwr_ctl_chk (
  input logic clk,
  input logic por_n,
  input logic rst_pin,
  input logic sys_rst,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic osc_run,
  input logic mode_idle,
  input logic mode_pdown
);
  assert_tick_halved_R1: assert property (@(posedge clk) disable iff (!por_n)
    per_clk_en |=> !per_clk_en);
  assert_rst_needs_pin_R2: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> $past(rst_pin));
  assert_cpu_under_per_R5: assert property (@(posedge clk) disable iff (!por_n)
    cpu_clk_en |-> per_clk_en);
  assert_pdown_silent_R7: assert property (@(posedge clk) disable iff (!por_n)
    (mode_pdown && !rst_pin) |-> (!per_clk_en && !osc_run));
  assert_pdown_exit_R8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(mode_pdown) |-> $past(sys_rst));
  assert_modes_excl_R9: assert property (@(posedge clk) disable iff (!por_n)
    !(mode_idle && mode_pdown));
endmodule

bind rst_pwr_ctl rst_pwr_ctl_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .sys_rst(sys_rst),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
  .mode_idle(mode_idle), .mode_pdown(mode_pdown)
);

// File: tb/sim_rst_pwr_ctl.sv
module sim_rst_pwr_ctl;
  logic clk = 0, por_n = 0, rst_pin = 1, pcon_we = 0, pcon_idl = 0, pcon_pd = 0, irq_pend = 0;
  logic [7:0] pcon_cur = 8'hFF;
  logic sys_rst, cpu_clk_en, per_clk_en, osc_run, mode_idle, mode_pdown;
  logic [7:0] port_rv, sp_rv, pcon_rv;
  int e = 0, total = 0, bad = 0;
  bit done = 0;

  typedef struct { int at; int sig; int val; string req; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  rst_pwr_ctl u0 (.*);

  always @(posedge clk) if (por_n) e <= e + 1;

  function automatic int pick(int s);
    case (s)
      0: return int'(sys_rst);
      1: return int'(cpu_clk_en);
      2: return int'(per_clk_en);
      3: return int'(osc_run);
      4: return int'(mode_idle);
      5: return int'(mode_pdown);
      6: return int'(port_rv);
      7: return int'(sp_rv);
      default: return int'(pcon_rv);
    endcase
  endfunction

  task automatic expect_at(int at, int sig, int val, string req);
    item_t it;
    it.at = at; it.sig = sig; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  task automatic after_edge(int n);
    while (e < n) @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= e) begin
      total++;
      if (q[0].at < e || pick(q[0].sig) != q[0].val) begin
        bad++;
        $display("FAIL %s at edge %0d sig %0d: got %0d expected %0d",
                 q[0].req, q[0].at, q[0].sig, pick(q[0].sig), q[0].val);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    // reset state and load values
    expect_at(1, 0, 0, "R2"); expect_at(1, 4, 0, "R8"); expect_at(1, 5, 0, "R8");
    expect_at(1, 3, 1, "R7");
    expect_at(5, 6, 8'hFF, "R10"); expect_at(5, 7, 8'h07, "R10"); expect_at(5, 8, 8'h10, "R10");
    expect_at(12, 8, 8'h00, "R10");
    expect_at(43, 0, 0, "R2"); expect_at(44, 0, 1, "R2");
    expect_at(67, 0, 1, "R4"); expect_at(68, 0, 0, "R4");
    expect_at(111, 0, 0, "R4"); expect_at(112, 0, 1, "R4");
    expect_at(135, 0, 1, "R4"); expect_at(136, 0, 0, "R4");
    expect_at(137, 2, 1, "R1"); expect_at(138, 2, 0, "R1"); expect_at(139, 2, 1, "R1");
    expect_at(157, 0, 0, "R3"); expect_at(181, 0, 0, "R3"); expect_at(205, 0, 0, "R3");
    expect_at(213, 4, 1, "R5"); expect_at(213, 1, 0, "R5"); expect_at(213, 2, 1, "R5");
    expect_at(231, 4, 1, "R6"); expect_at(231, 1, 0, "R6");
    expect_at(232, 4, 0, "R6"); expect_at(233, 1, 1, "R6");
    expect_at(243, 5, 1, "R9"); expect_at(243, 4, 0, "R9");
    expect_at(243, 3, 0, "R7"); expect_at(243, 2, 0, "R7"); expect_at(243, 1, 0, "R7");
    expect_at(290, 5, 1, "R7"); expect_at(290, 3, 0, "R7");
    expect_at(301, 3, 1, "R8");
    expect_at(334, 0, 0, "R8"); expect_at(335, 0, 1, "R8");
    expect_at(335, 5, 1, "R8"); expect_at(336, 5, 0, "R8");
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 por_n = 1;
    after_edge(10);  pcon_cur = 8'hEF;
    after_edge(50);  rst_pin = 0;
    after_edge(80);  rst_pin = 1;
    after_edge(120); rst_pin = 0;
    after_edge(140); rst_pin = 1;
    after_edge(150); rst_pin = 0;
    after_edge(169); rst_pin = 1;
    after_edge(185); rst_pin = 0;
    after_edge(210); pcon_we = 1; pcon_idl = 1;
    after_edge(211); pcon_we = 0; pcon_idl = 0;
    after_edge(215); irq_pend = 1;
    after_edge(216); irq_pend = 0;
    after_edge(240); pcon_we = 1; pcon_idl = 1; pcon_pd = 1;
    after_edge(241); pcon_we = 0; pcon_idl = 0; pcon_pd = 0;
    after_edge(249); irq_pend = 1;
    after_edge(260); irq_pend = 0;
    after_edge(300); rst_pin = 1;
    after_edge(345);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); total++; bad++; $display("FAIL watchdog expired"); end
    join_any
    disable fork;
    total += q.size(); bad += q.size();
    if (q.size() > 0) $display("FAIL %0d unchecked items, first %s: got %0d expected %0d",
                               q.size(), q[0].req, pick(q[0].sig), q[0].val);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule